// File: doc/BRIEF.md
# Converter Serial Result Port with Frame Abort

This block is the digital serial port of a sampling converter. The port is clocked by a serial clock from outside the block, and an active-low select frames each transfer. When the converter reports that a conversion has finished, the block latches the signed result and signals readiness on the data output. It then streams a 24-bit frame out while it shifts a channel-configuration byte in. At the end of the frame it issues a one-cycle start-conversion strobe.

The host can cut a frame short by releasing the select at any point after the first serial-clock rise. This also starts a new conversion at once. The new channel configuration is taken only if the host has completed at least the full command byte of falling edges. Otherwise the previous configuration stays in force. The converter itself is outside the block: it is represented by a conversion-done input and a result input.

Select and serial clock are sampled by the system clock `clk`. Each of their edges is acted on at the first `clk` edge that sees it.

Top module: `sadc_serial_if`

## Requirements
- R1: After a synchronous active-high `rst`, `chan` is 0, the port is converting (SDO reads 1 whenever select is low), and no start strobe has been issued.
- R2: `sdo_oe` is 1 exactly when `cs_n` is 0, with no delay.
- R3: While converting, SDO reads 1 with select low, and serial-clock edges produce no strobe and no frame.
- R4: A `conv_done` pulse while converting latches `result`. From the next cycle the port is ready and SDO reads 0, which is the active-low end-of-conversion bit and frame bit 0.
- R5: Frame bit k (k = 0..23) is shown after the k-th serial-clock fall. Bit 0 is 0, bit 1 is 0, and bit k for k >= 2 is `result[23-k]`: the sign at `result[21]` comes first, then the magnitude MSB first.
- R6: The 24th serial-clock fall ends the frame, gives exactly one one-cycle `conv_start` pulse and returns the port to converting.
- R7: A rise of `cs_n` after the first serial-clock rise and before the 24th fall aborts the frame. It gives one `conv_start` pulse and returns the port to converting.
- R8: A rise of `cs_n` while ready, before any serial-clock rise, is not an abort. No strobe is issued, and the result and the end-of-conversion indication are kept.
- R9: SDI is sampled on serial-clock rises. The first six bits, in arrival order, form `chan[5:0]` = {enable, single-ended, addr2, addr1, addr0, odd}.
- R10: `chan` is updated only when the frame ends, or is aborted, after at least 8 serial-clock falls. An abort after 0..7 falls, even one that follows the 8th rise, leaves `chan` unchanged.
- R11: A byte whose first bit (enable) is 0 leaves `chan` unchanged.
- R12: SDI bits 7 and 8 and all later SDI bits have no effect on `chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every other input |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial command data in |
| conv_done | input | 1 | Conversion finished, one-cycle pulse |
| result | input | 22 | Signed conversion result, sign at MSB |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for SDO (high impedance when 0) |
| conv_start | output | 1 | One-cycle start-conversion strobe |
| chan | output | 6 | Committed channel configuration |

## Verification
Every select or serial-clock edge is registered once, so SDO, `conv_start` and `chan` respond one `clk` cycle after the edge. `sdo_oe` responds in the same cycle. The bench holds each serial-clock level for four `clk` cycles and samples on the falling `clk` edge at the end of that hold, well past the one-cycle response. Strobes are counted on every rising `clk` edge and compared after each frame, so a missing strobe, an extra strobe or a stretched strobe is caught. A sweep aborts a frame after every possible count of falling edges, from 0 to 24, and adds extra rise-only aborts at the byte boundary.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
   typedef enum logic [1:0] {
      ST_CONV  = 2'd0,
      ST_READY = 2'd1,
      ST_XFER  = 2'd2
   } sif_state_e;
endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic rise,
   output logic fall
);
   logic q;

   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= din;
   end

   assign rise = din & ~q;
   assign fall = ~din & q;
endmodule

// File: rtl/sadc_frame_out.sv
module sadc_frame_out #(
   parameter int FRAME_W = 24,
   parameter int RES_W   = FRAME_W - 2,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [RES_W-1:0] res,
   input  logic [CNT_W-1:0] idx,
   output logic             bit_o
);
   logic [RES_W-1:0]   res_q;
   logic [FRAME_W-1:0] frame;

   initial begin
      assert (RES_W == FRAME_W - 2)
         else $error("result width must equal frame width minus two");
   end

   always_ff @(posedge clk) begin
      if (rst)       res_q <= '0;
      else if (load) res_q <= res;
   end

   // Frame word: end-of-conversion (low), fixed zero, then sign and magnitude.
   assign frame = {1'b0, 1'b0, res_q};

   always_comb begin
      bit_o = 1'b1;
      for (int i = 0; i < FRAME_W; i++) begin
         if (idx == CNT_W'(i)) bit_o = frame[FRAME_W-1-i];
      end
   end
endmodule

// File: rtl/sadc_chan_reg.sv
module sadc_chan_reg #(
   parameter int CH_W    = 6,
   parameter bit EN_GATE = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cap_en,
   input  logic            sdi,
   input  logic            commit,
   output logic [CH_W-1:0] chan
);
   logic [CH_W-1:0] cap_q;
   logic            accept;

   always_ff @(posedge clk) begin
      if (rst)         cap_q <= '0;
      else if (cap_en) cap_q <= {cap_q[CH_W-2:0], sdi};
   end

   generate
      if (EN_GATE) begin : g_gate
         assign accept = cap_q[CH_W-1];
      end else begin : g_nogate
         assign accept = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)                  chan <= '0;
      else if (commit && accept) chan <= cap_q;
   end
endmodule

// File: rtl/sadc_serial_if.sv
module sadc_serial_if
   import sadc_pkg::*;
#(
   parameter int FRAME_W = 24,
   parameter int CMD_W   = 8,
   parameter int CH_W    = 6,
   parameter bit EN_GATE = 1'b1,
   parameter int RES_W   = FRAME_W - 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cs_n,
   input  logic             sck,
   input  logic             sdi,
   input  logic             conv_done,
   input  logic [RES_W-1:0] result,
   output logic             sdo,
   output logic             sdo_oe,
   output logic             conv_start,
   output logic [CH_W-1:0]  chan
);
   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] CMD_CNT  = CNT_W'(CMD_W);
   localparam logic [CNT_W-1:0] CH_CNT   = CNT_W'(CH_W);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);

   initial begin
      assert (CH_W >= 2 && CH_W <= CMD_W)
         else $error("channel field must fit the command byte");
      assert (CMD_W <= FRAME_W)
         else $error("command byte longer than the frame");
   end

   sif_state_e       state_q;
   logic [CNT_W-1:0] fcnt_q, rcnt_q;
   logic             sck_rise, sck_fall, cs_rise, cs_fall;
   logic             frame_go, in_xfer, last_fall, cap_en, commit, load;
   logic             frame_bit;

   sadc_edge_det #(.RST_VAL(1'b0)) u_sck_edge (
      .clk(clk), .rst(rst), .din(sck), .rise(sck_rise), .fall(sck_fall));

   sadc_edge_det #(.RST_VAL(1'b1)) u_cs_edge (
      .clk(clk), .rst(rst), .din(cs_n), .rise(cs_rise), .fall(cs_fall));

   assign in_xfer   = (state_q == ST_XFER);
   assign frame_go  = (state_q == ST_READY) && !cs_n && sck_rise;
   assign last_fall = in_xfer && !cs_rise && sck_fall && (fcnt_q == LAST_CNT);
   assign cap_en    = frame_go ||
                      (in_xfer && !cs_rise && sck_rise && (rcnt_q < CH_CNT));
   assign commit    = in_xfer && ((cs_rise && fcnt_q >= CMD_CNT) || last_fall);
   assign load      = (state_q == ST_CONV) && conv_done;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= ST_CONV;
         fcnt_q     <= '0;
         rcnt_q     <= '0;
         conv_start <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         unique case (state_q)
            ST_CONV: begin
               fcnt_q <= '0;
               rcnt_q <= '0;
               if (conv_done) state_q <= ST_READY;
            end
            ST_READY: begin
               if (frame_go) begin
                  state_q <= ST_XFER;
                  rcnt_q  <= CNT_W'(1);
               end
            end
            ST_XFER: begin
               if (cs_rise) begin
                  state_q    <= ST_CONV;
                  conv_start <= 1'b1;
               end else if (sck_fall) begin
                  fcnt_q <= fcnt_q + 1'b1;
                  if (last_fall) begin
                     state_q    <= ST_CONV;
                     conv_start <= 1'b1;
                  end
               end else if (sck_rise && rcnt_q < CMD_CNT) begin
                  rcnt_q <= rcnt_q + 1'b1;
               end
            end
            default: state_q <= ST_CONV;
         endcase
      end
   end

   sadc_frame_out #(.FRAME_W(FRAME_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_frame (
      .clk(clk), .rst(rst), .load(load), .res(result), .idx(fcnt_q),
      .bit_o(frame_bit));

   sadc_chan_reg #(.CH_W(CH_W), .EN_GATE(EN_GATE)) u_chan (
      .clk(clk), .rst(rst), .cap_en(cap_en), .sdi(sdi), .commit(commit),
      .chan(chan));

   assign sdo    = (state_q == ST_CONV) ? 1'b1 : frame_bit;
   assign sdo_oe = ~cs_n;

   // Strobe lasts one cycle (R6).
   assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      conv_start |=> !conv_start);

   // Early select release in a frame starts a conversion next cycle (R7).
   assert_abort_start_R7: assert property (@(posedge clk) disable iff (rst)
      (in_xfer && cs_rise) |=> (conv_start && state_q == ST_CONV));

   // Channel changes only with a strobe after a full command byte (R10).
   assert_chan_commit_R10: assert property (@(posedge clk) disable iff (rst)
      !$stable(chan) |-> (conv_start && fcnt_q >= CMD_CNT));

   // Ready state presents the low end-of-conversion bit (R4).
   assert_eoc_low_R4: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_READY) |-> !sdo);

   // A select fall never lands inside a frame; output is driven after it (R2).
   assert_oe_on_select_R2: assert property (@(posedge clk) disable iff (rst)
      cs_fall |-> (sdo_oe && !in_xfer));
endmodule

// File: tb/sadc_serial_if_test.sv
module sadc_serial_if_test;
   localparam int BUSY = 40;

   logic        clk = 1'b0;
   logic        rst, cs_n, sck, sdi;
   logic        conv_done;
   logic [21:0] result;
   logic        sdo, sdo_oe, conv_start;
   logic [5:0]  chan;

   int n_chk = 0, n_fail = 0, n_start = 0, busy = 0;
   logic [5:0]  exp_chan = 6'd0;
   logic [21:0] cur_res;

   always #5 clk = ~clk;

   sadc_serial_if uut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi),
      .conv_done(conv_done), .result(result), .sdo(sdo), .sdo_oe(sdo_oe),
      .conv_start(conv_start), .chan(chan));

   // Converter model: busy for BUSY cycles after reset or a start strobe.
   always @(posedge clk) begin
      if (rst)             busy <= BUSY;
      else if (conv_start) busy <= BUSY;
      else if (busy != 0)  busy <= busy - 1;
      if (!rst && conv_start) n_start = n_start + 1;
   end
   assign conv_done = (busy == 1);

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic exp_bit(input int k, input logic [21:0] r);
      if (k < 2) return 1'b0;
      return r[23-k];
   endfunction

   task automatic run_frame(input logic [7:0] cmd, input int nfull, input bit xr,
                            input logic [23:0] filler);
      int s0 = n_start;
      bool_t: begin end
      cs_n = 1'b0;
      tick(2);
      chk(sdo == 1'b0, "R4 eoc bit", sdo, 0);
      chk(sdo_oe == 1'b1, "R2 oe low select", sdo_oe, 1);
      for (int k = 1; k <= nfull; k++) begin
         sdi = (k <= 8) ? cmd[8-k] : filler[k % 24];
         sck = 1'b1;
         tick(4);
         sck = 1'b0;
         tick(4);
         if (k < 24) chk(sdo == exp_bit(k, cur_res), "R5 frame bit", sdo, exp_bit(k, cur_res));
      end
      if (xr) begin
         sdi = (nfull < 8) ? cmd[7-nfull] : filler[0];
         sck = 1'b1;
         tick(4);
      end
      cs_n = 1'b1;
      tick(1);
      chk(sdo_oe == 1'b0, "R2 oe high select", sdo_oe, 0);
      tick(2);
      sck = 1'b0;
      // Abort or full frame gives one strobe (R6, R7); plain release gives none (R8).
      if (nfull >= 24)
         chk(n_start - s0 == 1, "R6 full frame strobe", n_start - s0, 1);
      else if (nfull >= 1 || xr)
         chk(n_start - s0 == 1, "R7 abort strobe", n_start - s0, 1);
      else
         chk(n_start - s0 == 0, "R8 no strobe", n_start - s0, 0);
      // R9 R10 R11 R12: commit only after 8 falls with enable set.
      if (nfull >= 8 && cmd[7]) exp_chan = cmd[7:2];
      chk(chan == exp_chan, "R9 R10 R11 R12 chan", chan, exp_chan);
      if (nfull == 0 && !xr) begin
         cs_n = 1'b0;
         tick(2);
         chk(sdo == 1'b0, "R8 still ready", sdo, 0);
         cs_n = 1'b1;
         tick(2);
      end else begin
         result = result * 22'd5 + 22'h13579B;
         cur_res = result;
         cs_n = 1'b0;
         tick(1);
         chk(sdo == 1'b1, "R3 busy reads 1", sdo, 1);
         s0 = n_start;
         sck = 1'b1; tick(3); sck = 1'b0; tick(3);
         chk(sdo == 1'b1 && n_start == s0, "R3 sck ignored", n_start - s0, 0);
         cs_n = 1'b1;
         tick(BUSY + 10);
      end
   endtask

   initial begin
      rst = 1'b1; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
      result = 22'h2A5C31;
      cur_res = result;
      tick(3);
      rst = 1'b0;
      tick(1);
      chk(sdo_oe == 1'b0, "R1 R2 oe off", sdo_oe, 0);
      chk(chan == 6'd0, "R1 chan zero", chan, 0);
      cs_n = 1'b0;
      tick(1);
      chk(sdo == 1'b1, "R1 converting", sdo, 1);
      chk(n_start == 0, "R1 no strobe", n_start, 0);
      cs_n = 1'b1;
      tick(BUSY + 10);

      run_frame(8'b1_0_101_1_01, 24, 1'b0, 24'hF0F0F0);
      run_frame(8'b0_1_010_0_11, 24, 1'b0, 24'h0FF00F);   // R11 enable clear
      for (int a = 0; a <= 24; a++) begin
         logic [7:0] c = 8'h80 | 8'((a * 37 + 11) & 8'h7F);
         run_frame(c, a, 1'b0, 24'h5A5A5A ^ 24'(a));
      end
      run_frame(8'b1_1_111_0_00, 7, 1'b1, 24'hFFFFFF);    // R10 8 rises, 7 falls
      run_frame(8'b1_0_001_1_00, 0, 1'b1, 24'h000000);    // R7 abort after 1st rise
      run_frame(8'b1_1_000_1_11, 8, 1'b0, 24'h123456);    // R10 exactly 8 falls
      run_frame(8'b1_0_110_0_10, 24, 1'b0, 24'hA5A5A5);   // R12 later bits vary

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule